// File: doc/BRIEF.md
# Shield Mesh Tamper Monitor

This block guards a crypto island by watching a set of shield wires laid over it. Each cycle it sends a fresh pseudo-random word out on the shield lanes. After the known round-trip delay it checks that the same word comes back at the far end. A cut, a short or a rerouted wire makes the returned bits differ from the expected ones. An external clock-monitor fault counts as the same kind of event.

The first such event latches a tamper state that only reset can clear. The tamper state drops the crypto enable and raises an alert to the host. It also starts a wipe that clears the on-chip key store one word per cycle and then raises a done flag. The host can acknowledge the alert, but the halt stays in force. While the block is untampered, the key store is loaded through a simple write port. Its contents feed the crypto core directly.

The comparison stays off for the first round-trip-latency cycles after reset. Until then the returned lanes do not yet carry pattern bits sent after reset.

Top module: `shield_mesh_monitor`

## Requirements
- R1: During reset and in the first cycle after it, crypto_en is 1 and alert, zeroize and zero_done are 0. Every key word reads as zero.
- R2: The word driven on mesh_drive comes from a maximal-length LFSR that advances every cycle. Over 64 consecutive cycles it takes at least 8 distinct values.
- R3: While mesh_return equals mesh_drive delayed by LATENCY cycles, no tamper is ever raised.
- R4: Once the comparison is armed, a difference in any single lane between mesh_return and the delayed drive word drives crypto_en to 0 and alert to 1 at the next clock edge.
- R5: Mismatches in the first LATENCY cycles after reset are ignored. The first cycle after reset counts as cycle 0.
- R6: clk_fault high in any cycle gives the same response as a mesh mismatch at the next edge.
- R7: From the edge that latches the first tamper event, zeroize is 1 for exactly KEY_WORDS cycles. After that, zeroize is 0, zero_done is 1 and every key word is zero.
- R8: The halt is sticky. crypto_en stays 0 after the faulty condition is gone and after a host acknowledge, until reset.
- R9: host_ack clears alert at the next edge unless a tamper event is present in the same cycle. In that case alert stays 1.
- R10: A key write (key_wr_en, word index key_wr_idx, word i at bits i*KEY_W) updates its word at the next edge only when the block is untampered and no tamper event is present in that cycle. Otherwise the write is dropped.
- R11: Reset after a tamper restores crypto_en to 1, clears zero_done and restarts the pattern and the arming window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mesh_drive | output | LANES | Pattern word driven onto the shield lanes |
| mesh_return | input | LANES | Word received back from the far end of the lanes |
| clk_fault | input | 1 | Clock-monitor fault indication |
| host_ack | input | 1 | Host acknowledge of the alert |
| key_wr_en | input | 1 | Key word write strobe |
| key_wr_idx | input | $clog2(KEY_WORDS) | Key word index |
| key_wr_data | input | KEY_W | Key word data |
| key_flat | output | KEY_WORDS*KEY_W | Key store contents, word i at bits i*KEY_W |
| crypto_en | output | 1 | Crypto enable, 0 once halted |
| alert | output | 1 | Tamper alert to the host |
| zeroize | output | 1 | High while the key wipe is in progress |
| zero_done | output | 1 | Wipe complete |

## Verification
A key write and a tamper event can arrive in the same cycle. The write must lose: the word must not take the new value even for the one cycle before the wipe reaches it. The bench provokes this by raising a lane corruption together with a write to word 0. It then reads word 0 in the cycle after the trigger edge, where the old value must still be present. A second collision pairs host_ack with a clock fault that arrives while the block is already tampered. Here the alert must stay raised.

// File: rtl/shield_pkg.sv
// Shared definitions for the shield mesh monitor.
// Holds the LFSR step function so the generator and any model use one rule.
package shield_pkg;

    localparam int unsigned STEP_W = 32;

    // One Galois right-shift step; taps placed in the low bits of a 32-bit word.
    function automatic logic [STEP_W-1:0] galois_step(
        input logic [STEP_W-1:0] state,
        input logic [STEP_W-1:0] taps
    );
        logic [STEP_W-1:0] nxt;
        nxt = state >> 1;
        if (state[0]) begin
            nxt = nxt ^ taps;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/mesh_lfsr.sv
// Pattern source for the shield lanes.
// Assumes: SEED is non-zero and TAPS give a maximal-length polynomial of width W.
// The state loads SEED in reset and advances one step every cycle after it.
module mesh_lfsr #(
    parameter int unsigned W     = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [LANES-1:0] lanes
);
    import shield_pkg::*;

    logic [W-1:0]      state;
    logic [STEP_W-1:0] stepped;

    // Next state through the shared step function.
    always_comb begin
        stepped = galois_step(STEP_W'(state), STEP_W'(TAPS));
    end

    // State register: seed on reset, one step per cycle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= stepped[W-1:0];
        end
    end

    assign lanes = state[LANES-1:0];

endmodule

// File: rtl/mesh_compare.sv
// Delays the driven pattern by the mesh round trip and compares it with the
// returned lanes. Assumes the mesh path is exactly LATENCY register stages
// on the same clock. The comparison is armed only after LATENCY cycles of reset.
module mesh_compare #(
    parameter int unsigned LANES   = 4,
    parameter int unsigned LATENCY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] sent,
    input  logic [LANES-1:0] returned,
    output logic             trip
);
    localparam int unsigned CW = $clog2(LATENCY + 1);

    logic [LANES-1:0] stage [LATENCY];
    logic [CW-1:0]    arm_cnt;
    logic             armed;

    // First expected-value stage takes the word being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage[0] <= '0;
        end else begin
            stage[0] <= sent;
        end
    end

    // Remaining stages form the modelled round trip.
    for (genvar g = 1; g < LATENCY; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[g] <= '0;
            end else begin
                stage[g] <= stage[g-1];
            end
        end
    end

    assign armed = (arm_cnt == CW'(LATENCY));

    // Arming counter: saturates once the pipeline holds post-reset words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_cnt <= '0;
        end else if (!armed) begin
            arm_cnt <= arm_cnt + CW'(1);
        end
    end

    // Mismatch on any lane once armed.
    always_comb begin
        trip = armed && (returned != stage[LATENCY-1]);
    end

endmodule

// File: rtl/key_vault.sv
// Small key store with a one-way wipe sequencer.
// A start pulse wipes one word per cycle from word 0 upward, then sets done.
// Writes are accepted only when the caller passes wr_ok and no wipe is active.
module key_vault #(
    parameter int unsigned KEY_WORDS = 4,
    parameter int unsigned KEY_W     = 32,
    localparam int unsigned IDX_W    = $clog2(KEY_WORDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       wr_ok,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [KEY_W-1:0]           wr_data,
    output logic [KEY_WORDS*KEY_W-1:0] key_flat,
    output logic                       busy,
    output logic                       done
);
    logic [KEY_W-1:0] words [KEY_WORDS];
    logic [IDX_W-1:0] ptr;

    // Wipe sequencer: start, then one word per cycle, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            ptr  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            ptr  <= '0;
        end else if (busy) begin
            if (ptr == IDX_W'(KEY_WORDS - 1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                ptr <= ptr + IDX_W'(1);
            end
        end
    end

    // Per-word storage: wipe has priority over a write.
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (busy && ptr == IDX_W'(g)) begin
                words[g] <= '0;
            end else if (wr_ok && !start && !busy && wr_idx == IDX_W'(g)) begin
                words[g] <= wr_data;
            end
        end
        assign key_flat[g*KEY_W +: KEY_W] = words[g];
    end

endmodule

// File: rtl/shield_mesh_monitor.sv
// Top of the shield mesh tamper monitor.
// Drives the pattern, compares the return, latches tamper and alert, and runs
// the key wipe. Assumes clk_fault and mesh_return are synchronous to clk.
module shield_mesh_monitor #(
    parameter int unsigned LANES     = 4,
    parameter int unsigned LATENCY   = 3,
    parameter int unsigned KEY_WORDS = 4,
    parameter int unsigned KEY_W     = 32,
    parameter int unsigned LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int unsigned IDX_W    = $clog2(KEY_WORDS),
    localparam int unsigned KEY_BITS = KEY_WORDS * KEY_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [LANES-1:0]     mesh_drive,
    input  logic [LANES-1:0]     mesh_return,
    input  logic                 clk_fault,
    input  logic                 host_ack,
    input  logic                 key_wr_en,
    input  logic [IDX_W-1:0]     key_wr_idx,
    input  logic [KEY_W-1:0]     key_wr_data,
    output logic [KEY_BITS-1:0]  key_flat,
    output logic                 crypto_en,
    output logic                 alert,
    output logic                 zeroize,
    output logic                 zero_done
);
    logic mesh_trip;
    logic event_hit;
    logic tampered;
    logic alert_q;
    logic wipe_start;
    logic write_ok;

    mesh_lfsr #(
        .W     (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED),
        .LANES (LANES)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .lanes (mesh_drive)
    );

    mesh_compare #(
        .LANES   (LANES),
        .LATENCY (LATENCY)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sent     (mesh_drive),
        .returned (mesh_return),
        .trip     (mesh_trip)
    );

    // Any anomaly source this cycle.
    always_comb begin
        event_hit  = mesh_trip || clk_fault;
        wipe_start = event_hit && !tampered;
        write_ok   = key_wr_en && !event_hit && !tampered;
    end

    // Sticky tamper latch and host alert with acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tampered <= 1'b0;
            alert_q  <= 1'b0;
        end else if (event_hit) begin
            tampered <= 1'b1;
            alert_q  <= 1'b1;
        end else if (host_ack) begin
            alert_q  <= 1'b0;
        end
    end

    key_vault #(
        .KEY_WORDS (KEY_WORDS),
        .KEY_W     (KEY_W)
    ) u_vault (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wipe_start),
        .wr_ok    (write_ok),
        .wr_idx   (key_wr_idx),
        .wr_data  (key_wr_data),
        .key_flat (key_flat),
        .busy     (zeroize),
        .done     (zero_done)
    );

    assign crypto_en = !tampered;
    assign alert     = alert_q;

endmodule

// File: rtl/shield_mesh_monitor_sva.sv
// Property checker for the shield mesh monitor, attached by bind.
// Observes ports and the internal mesh trip signal only.
module shield_mesh_monitor_sva #(
    parameter int unsigned KEY_BITS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mesh_trip,
    input logic                clk_fault,
    input logic                host_ack,
    input logic                crypto_en,
    input logic                alert,
    input logic                zeroize,
    input logic                zero_done,
    input logic [KEY_BITS-1:0] key_flat
);
    assert_trip_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mesh_trip |=> (!crypto_en && alert));

    assert_fault_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fault |=> (!crypto_en && alert));

    assert_wipe_on_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crypto_en) |-> zeroize);

    assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_done |-> (key_flat == '0 && !zeroize));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !crypto_en |=> !crypto_en);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !mesh_trip && !clk_fault) |=> !alert);

    assert_key_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!crypto_en && !zeroize) |=> $stable(key_flat));

endmodule

bind shield_mesh_monitor shield_mesh_monitor_sva #(
    .KEY_BITS (KEY_WORDS * KEY_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .mesh_trip (mesh_trip),
    .clk_fault (clk_fault),
    .host_ack  (host_ack),
    .crypto_en (crypto_en),
    .alert     (alert),
    .zeroize   (zeroize),
    .zero_done (zero_done),
    .key_flat  (key_flat)
);

// File: tb/shield_mesh_monitor_tb.sv
// Directed bench: the mesh is a LATENCY-stage delay line with a corruption mask.
module shield_mesh_monitor_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned LANES      = 4;
    localparam int unsigned LAT        = 3;
    localparam int unsigned KW         = 4;
    localparam int unsigned KB         = 32;
    localparam int unsigned IW         = $clog2(KW);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LANES-1:0]  mesh_drive;
    logic [LANES-1:0]  mesh_return;
    logic [LANES-1:0]  corrupt = '0;
    logic              clk_fault = 1'b0;
    logic              host_ack = 1'b0;
    logic              key_wr_en = 1'b0;
    logic [IW-1:0]     key_wr_idx = '0;
    logic [KB-1:0]     key_wr_data = '0;
    logic [KW*KB-1:0]  key_flat;
    logic              crypto_en, alert, zeroize, zero_done;
    logic [LANES-1:0]  dl [LAT];

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Mesh model: fixed round-trip delay plus a corruption mask.
    always_ff @(posedge clk) begin
        dl[0] <= mesh_drive;
        for (int i = 1; i < LAT; i++) dl[i] <= dl[i-1];
    end
    assign mesh_return = dl[LAT-1] ^ corrupt;

    shield_mesh_monitor #(
        .LANES(LANES), .LATENCY(LAT), .KEY_WORDS(KW), .KEY_W(KB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mesh_drive(mesh_drive), .mesh_return(mesh_return),
        .clk_fault(clk_fault), .host_ack(host_ack), .key_wr_en(key_wr_en),
        .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data), .key_flat(key_flat),
        .crypto_en(crypto_en), .alert(alert), .zeroize(zeroize), .zero_done(zero_done)
    );

    task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; corrupt = '0; clk_fault = 1'b0; host_ack = 1'b0; key_wr_en = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic load_word(input int idx, input logic [KB-1:0] data);
        key_wr_en = 1'b1; key_wr_idx = IW'(idx); key_wr_data = data;
        tick();
        key_wr_en = 1'b0;
    endtask

    task automatic load_all();
        for (int i = 0; i < KW; i++) load_word(i, 32'hC0DE_0000 + 32'(i * 17 + 1));
    endtask

    function automatic logic [KW*KB-1:0] loaded_key();
        logic [KW*KB-1:0] k;
        for (int i = 0; i < KW; i++) k[i*KB +: KB] = 32'hC0DE_0000 + 32'(i * 17 + 1);
        return k;
    endfunction

    task automatic t_reset_state();
        rst_n = 1'b0; tick();
        check("R1 crypto_en in reset", 128'(crypto_en), 128'(1));
        do_reset();
        check("R1 crypto_en", 128'(crypto_en), 128'(1));
        check("R1 alert", 128'(alert), 128'(0));
        check("R1 zeroize", 128'(zeroize), 128'(0));
        check("R1 zero_done", 128'(zero_done), 128'(0));
        check("R1 key zero", 128'(key_flat), 128'(0));
    endtask

    task automatic t_pattern_and_quiet();
        logic [(1<<LANES)-1:0] seen;
        int distinct;
        seen = '0;
        do_reset();
        for (int i = 0; i < 64; i++) begin
            seen[mesh_drive] = 1'b1;
            tick();
        end
        distinct = $countones(seen);
        check("R2 distinct pattern words >= 8", 128'(distinct >= 8), 128'(1));
        repeat (200) tick();
        check("R3 no tamper on clean mesh", 128'(crypto_en), 128'(1));
        check("R3 no alert on clean mesh", 128'(alert), 128'(0));
    endtask

    task automatic t_arm_window();
        do_reset();
        corrupt = '1;
        repeat (LAT) tick();
        corrupt = '0;
        repeat (20) tick();
        check("R5 early mismatch ignored crypto_en", 128'(crypto_en), 128'(1));
        check("R5 early mismatch ignored alert", 128'(alert), 128'(0));
    endtask

    task automatic t_lane_cut();
        for (int lane = 0; lane < LANES; lane++) begin
            do_reset();
            repeat (LAT + 5) tick();
            corrupt = LANES'(1) << lane;
            tick();
            corrupt = '0;
            check($sformatf("R4 lane %0d cut halts", lane), 128'(crypto_en), 128'(0));
            check($sformatf("R4 lane %0d cut alerts", lane), 128'(alert), 128'(1));
        end
    endtask

    task automatic t_load_and_wipe();
        int n;
        do_reset();
        load_all();
        check("R10 key load accepted", 128'(key_flat), 128'(loaded_key()));
        repeat (LAT + 2) tick();
        corrupt = 4'b0100;
        tick();
        corrupt = '0;
        check("R7 zeroize starts", 128'(zeroize), 128'(1));
        n = 1;
        while (n < 20) begin
            tick();
            if (!zeroize) break;
            n++;
        end
        check("R7 zeroize length", 128'(n), 128'(KW));
        check("R7 zero_done", 128'(zero_done), 128'(1));
        check("R7 key wiped", 128'(key_flat), 128'(0));
        repeat (10) tick();
        check("R8 halt persists", 128'(crypto_en), 128'(0));
        host_ack = 1'b1; tick(); host_ack = 1'b0;
        check("R9 ack clears alert", 128'(alert), 128'(0));
        check("R8 ack keeps halt", 128'(crypto_en), 128'(0));
        load_word(1, 32'h1234_5678);
        check("R10 write after tamper dropped", 128'(key_flat), 128'(0));
        clk_fault = 1'b1; host_ack = 1'b1; tick();
        clk_fault = 1'b0; host_ack = 1'b0;
        check("R9 event beats ack", 128'(alert), 128'(1));
        do_reset();
        check("R11 reset restores crypto_en", 128'(crypto_en), 128'(1));
        check("R11 reset clears done", 128'(zero_done), 128'(0));
        repeat (30) tick();
        check("R11 clean run after reset", 128'(crypto_en), 128'(1));
    endtask

    task automatic t_collision();
        logic [KW*KB-1:0] k;
        do_reset();
        load_all();
        repeat (LAT + 2) tick();
        corrupt = 4'b0001;
        key_wr_en = 1'b1; key_wr_idx = '0; key_wr_data = 32'hDEAD_BEEF;
        tick();
        corrupt = '0; key_wr_en = 1'b0;
        k = loaded_key();
        check("R10 write in trigger cycle dropped", 128'(key_flat[KB-1:0]), 128'(k[KB-1:0]));
        check("R4 collision halts", 128'(crypto_en), 128'(0));
    endtask

    task automatic t_clk_fault();
        do_reset();
        load_all();
        clk_fault = 1'b1; tick(); clk_fault = 1'b0;
        check("R6 fault halts", 128'(crypto_en), 128'(0));
        check("R6 fault alerts", 128'(alert), 128'(1));
        check("R6 fault wipes", 128'(zeroize), 128'(1));
        repeat (KW) tick();
        check("R6 fault wipe done", 128'(zero_done), 128'(1));
        check("R6 fault key zero", 128'(key_flat), 128'(0));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        tick();
        t_reset_state();
        t_pattern_and_quiet();
        t_arm_window();
        t_lane_cut();
        t_load_and_wipe();
        t_collision();
        t_clk_fault();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule